// File: doc/BRIEF.md
# Per-Hart Timer and Software Interrupt Unit

This unit sits on a 32-bit register bus in a multi-hart system. It provides a machine software interrupt line and a machine timer interrupt line for each hart. A hart raises a software interrupt on another hart by writing a nonzero word to that hart's pending slot. A zero write clears it. Reads of the slot return the pending bit.

All harts share one 64-bit time counter. It advances by one on each clock where the timebase tick enable is high. Software reads it as two 32-bit words and cannot write it. Each hart has a 64-bit compare value, written and read as two 32-bit halves. The hart's timer interrupt is a level. The comparison is made on every cycle, and the line is high whenever the compare value is at or below the current time. A handler silences the line by writing a later deadline.

The number of harts and the base offsets of the three regions are parameters. Reads are combinational: the read data follows the address within the same cycle.

Top module: `hart_irq_timer`

## Requirements
- R1: After reset, every pending bit is 0, every compare value is 0 and the time counter is 0. As a result, every timer line is high once reset is released.
- R2: An aligned write to address SWI_BASE + 4*h sets software line h to 1 if the write data is nonzero and to 0 if it is zero. The new level is visible on the line after that clock edge.
- R3: A read of address SWI_BASE + 4*h returns the pending bit of hart h in bit 0, with all other bits 0.
- R4: The compare value of hart h occupies address CMP_BASE + 8*h (bits 31:0) and address CMP_BASE + 8*h + 4 (bits 63:32). Writing one half leaves the other half unchanged, and both halves read back what was written.
- R5: The time counter increments on each clock edge where tickEn is high. Its bits 31:0 are read at TIME_BASE and its bits 63:32 at TIME_BASE + 4.
- R6: Writes to either time word leave the counter unchanged.
- R7: Timer line h is high exactly while compare(h) <= time. The comparison is made every cycle using the register values after the most recent edge, so a compare write or a tick takes effect in the following cycle.
- R8: An access with address bits 1:0 nonzero, or to an address outside the three regions, reads 0 and its write changes nothing.
- R9: Addresses for hart indices at or above NUM_HARTS (for example SWI_BASE + 4*NUM_HARTS) read 0 and ignore writes.
- R10: busRdata reflects the addressed register combinationally, in the same cycle the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Timebase tick enable; the counter advances on edges where it is high |
| busAddr | input | ADDR_W | Byte address of the access |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| swIrq | output | NUM_HARTS | Software interrupt line per hart |
| tmrIrq | output | NUM_HARTS | Timer interrupt line per hart |

## Verification
Read data is due in the same cycle as the address. The bench drives each access just after a falling edge and compares busRdata one time unit later, against a model holding the state of the previous rising edge. Pending bits, compare halves and the time counter change on the rising edge that samples the strobe, so both interrupt vectors are due in the next cycle. The model applies writes and ticks only after that edge. The model compares the two vectors, together with the read word, in every cycle. That includes the exact cycle in which the time counter reaches a compare value.

// File: rtl/hart_irq_timer_pkg.sv
package hart_irq_timer_pkg;
  localparam int HART_IDX_W = 8;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SWI,
    SEL_CMP_LO,
    SEL_CMP_HI,
    SEL_TIME_LO,
    SEL_TIME_HI
  } regSel_e;

  typedef struct packed {
    logic                  wrEn;
    regSel_e               sel;
    logic [HART_IDX_W-1:0] hart;
  } busStrobe_t;
endpackage

// File: rtl/hart_irq_timer_ctrl.sv
module hart_irq_timer_ctrl
  import hart_irq_timer_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int ADDR_W    = 16,
  parameter int SWI_BASE  = 'h0000,
  parameter int CMP_BASE  = 'h4000,
  parameter int TIME_BASE = 'hBFF8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output busStrobe_t        strb
);
  localparam int SWI_END = SWI_BASE + 4 * NUM_HARTS;
  localparam int CMP_END = CMP_BASE + 8 * NUM_HARTS;

  logic [ADDR_W-1:0] swiOff;
  logic [ADDR_W-1:0] cmpOff;
  int                addrVal;

  always_comb begin
    addrVal   = int'({{(32 - ADDR_W){1'b0}}, busAddr});
    swiOff    = busAddr - ADDR_W'(SWI_BASE);
    cmpOff    = busAddr - ADDR_W'(CMP_BASE);
    strb.wrEn = busWe;
    strb.sel  = SEL_NONE;
    strb.hart = '0;
    if (busAddr[1:0] == 2'b00) begin
      if (addrVal >= SWI_BASE && addrVal < SWI_END) begin
        strb.sel  = SEL_SWI;
        strb.hart = HART_IDX_W'(swiOff >> 2);
      end else if (addrVal >= CMP_BASE && addrVal < CMP_END) begin
        strb.sel  = cmpOff[2] ? SEL_CMP_HI : SEL_CMP_LO;
        strb.hart = HART_IDX_W'(cmpOff >> 3);
      end else if (addrVal == TIME_BASE) begin
        strb.sel = SEL_TIME_LO;
      end else if (addrVal == TIME_BASE + 4) begin
        strb.sel = SEL_TIME_HI;
      end
    end
  end
endmodule

// File: rtl/hart_irq_timer_dp.sv
module hart_irq_timer_dp
  import hart_irq_timer_pkg::*;
#(
  parameter int NUM_HARTS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  busStrobe_t           strb,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  output logic [NUM_HARTS-1:0] swIrq,
  output logic [NUM_HARTS-1:0] tmrIrq
);
  logic [63:0] timeCnt;
  logic [63:0] cmpArr [NUM_HARTS];

  always_ff @(posedge clk) begin
    if (!rstN)       timeCnt <= '0;
    else if (tickEn) timeCnt <= timeCnt + 64'd1;
  end

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    logic        hit;
    logic        swiBit;
    logic [63:0] cmpVal;

    assign hit = strb.wrEn && (int'(strb.hart) == h);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        swiBit <= 1'b0;
        cmpVal <= '0;
      end else if (hit) begin
        case (strb.sel)
          SEL_SWI:    swiBit        <= |busWdata;
          SEL_CMP_LO: cmpVal[31:0]  <= busWdata;
          SEL_CMP_HI: cmpVal[63:32] <= busWdata;
          default:    ;
        endcase
      end
    end

    assign swIrq[h]  = swiBit;
    assign tmrIrq[h] = (cmpVal <= timeCnt);
    assign cmpArr[h] = cmpVal;
  end

  logic [63:0] cmpSel;
  logic        swiSel;

  always_comb begin
    cmpSel = '0;
    swiSel = 1'b0;
    for (int h = 0; h < NUM_HARTS; h++) begin
      if (int'(strb.hart) == h) begin
        cmpSel = cmpArr[h];
        swiSel = swIrq[h];
      end
    end
    case (strb.sel)
      SEL_SWI:     busRdata = {31'd0, swiSel};
      SEL_CMP_LO:  busRdata = cmpSel[31:0];
      SEL_CMP_HI:  busRdata = cmpSel[63:32];
      SEL_TIME_LO: busRdata = timeCnt[31:0];
      SEL_TIME_HI: busRdata = timeCnt[63:32];
      default:     busRdata = '0;
    endcase
  end
endmodule

// File: rtl/hart_irq_timer.sv
module hart_irq_timer
  import hart_irq_timer_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int ADDR_W    = 16,
  parameter int SWI_BASE  = 'h0000,
  parameter int CMP_BASE  = 'h4000,
  parameter int TIME_BASE = 'hBFF8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWe,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  output logic [NUM_HARTS-1:0] swIrq,
  output logic [NUM_HARTS-1:0] tmrIrq
);
  busStrobe_t strb;

  hart_irq_timer_ctrl #(
    .NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W), .SWI_BASE(SWI_BASE),
    .CMP_BASE(CMP_BASE), .TIME_BASE(TIME_BASE)
  ) u_ctrl (
    .busAddr(busAddr), .busWe(busWe), .strb(strb)
  );

  hart_irq_timer_dp #(.NUM_HARTS(NUM_HARTS)) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strb(strb),
    .busWdata(busWdata), .busRdata(busRdata), .swIrq(swIrq), .tmrIrq(tmrIrq)
  );
endmodule

// File: rtl/hart_irq_timer_chk.sv
module hart_irq_timer_chk #(
  parameter int NUM_HARTS = 4,
  parameter int ADDR_W    = 16,
  parameter int SWI_BASE  = 'h0000
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 tickEn,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWe,
  input logic [31:0]          busWdata,
  input logic [31:0]          busRdata,
  input logic [NUM_HARTS-1:0] swIrq,
  input logic [NUM_HARTS-1:0] tmrIrq
);
  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_swi
    p_swi_write_r2: assert property (@(posedge clk) disable iff (!rstN)
      (busWe && busAddr == ADDR_W'(SWI_BASE + 4 * h)) |=> (swIrq[h] == ($past(busWdata) != 32'd0)));
  end

  p_swi_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |=> $stable(swIrq));

  p_tmr_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busWe && !tickEn) |=> $stable(tmrIrq));

  p_tmr_no_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |=> ((tmrIrq & $past(tmrIrq)) == $past(tmrIrq)));

  p_misaligned_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[1:0] != 2'b00) |-> (busRdata == 32'd0));

  p_hi_bits_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[1:0] == 2'b00 && busAddr < ADDR_W'(SWI_BASE + 4 * NUM_HARTS)
      && busAddr >= ADDR_W'(SWI_BASE)) |-> (busRdata[31:1] == 31'd0));
endmodule

bind hart_irq_timer hart_irq_timer_chk #(
  .NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W), .SWI_BASE(SWI_BASE)
) u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr), .busWe(busWe),
  .busWdata(busWdata), .busRdata(busRdata), .swIrq(swIrq), .tmrIrq(tmrIrq)
);

// File: tb/sim_hart_irq_timer.sv
module sim_hart_irq_timer;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int SWB = 'h0000;
  localparam int CMB = 'h4000;
  localparam int TMB = 'hBFF8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tickEn = 1'b0;
  logic [15:0]   busAddr = '0;
  logic          busWe = 1'b0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [N-1:0]  swIrq;
  logic [N-1:0]  tmrIrq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  bit [63:0] mCmp [N];
  bit        mSwi [N];
  bit [63:0] mTime;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hart_irq_timer #(.NUM_HARTS(N), .ADDR_W(16), .SWI_BASE(SWB), .CMP_BASE(CMB), .TIME_BASE(TMB)) u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .swIrq(swIrq), .tmrIrq(tmrIrq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mRead(input int a);
    if (a % 4 != 0) return 32'd0;
    if (a >= SWB && a < SWB + 4 * N) return {31'd0, mSwi[(a - SWB) / 4]};
    if (a >= CMB && a < CMB + 8 * N)
      return ((a - CMB) % 8 == 0) ? mCmp[(a - CMB) / 8][31:0] : mCmp[(a - CMB) / 8][63:32];
    if (a == TMB) return mTime[31:0];
    if (a == TMB + 4) return mTime[63:32];
    return 32'd0;
  endfunction

  function automatic string rdTag(input int a);
    if (a % 4 != 0) return "R10 R8";
    if (a >= SWB && a < SWB + 4 * N) return "R10 R3";
    if (a >= CMB && a < CMB + 8 * N) return "R10 R4";
    if (a == TMB || a == TMB + 4) return "R10 R5";
    return "R10 R8";
  endfunction

  task automatic mWrite(input int a, input logic [31:0] d);
    if (a % 4 != 0) return;
    if (a >= SWB && a < SWB + 4 * N) mSwi[(a - SWB) / 4] = (d != 0);
    else if (a >= CMB && a < CMB + 8 * N) begin
      if ((a - CMB) % 8 == 0) mCmp[(a - CMB) / 8][31:0] = d;
      else mCmp[(a - CMB) / 8][63:32] = d;
    end
  endtask

  task automatic step(input logic we, input int a, input logic [31:0] d, input logic tk, input string tag);
    logic [N-1:0] expSw, expTm;
    @(negedge clk);
    busWe = we; busAddr = a[15:0]; busWdata = d; tickEn = tk;
    #1;
    for (int h = 0; h < N; h++) begin
      expSw[h] = mSwi[h];
      expTm[h] = (mCmp[h] <= mTime);
    end
    chk((tag == "") ? rdTag(a) : tag, {32'd0, busRdata}, {32'd0, mRead(a)});
    chk("R2 swIrq", {60'd0, swIrq}, {60'd0, expSw});
    chk("R7 tmrIrq", {60'd0, tmrIrq}, {60'd0, expTm});
    @(posedge clk);
    if (we) mWrite(a, d);
    if (tk) mTime = mTime + 64'd1;
  endtask

  initial begin
    for (int h = 0; h < N; h++) begin mCmp[h] = '0; mSwi[h] = 0; end
    mTime = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 swIrq reset", {60'd0, swIrq}, 64'd0);
    chk("R1 tmrIrq reset", {60'd0, tmrIrq}, {60'd0, {N{1'b1}}});
    chk("R1 read reset", {32'd0, busRdata}, 64'd0);
    step(0, TMB, 0, 0, "R1 time reset");
    // R5: ticking time, read both words
    for (int i = 0; i < 6; i++) step(0, TMB, 0, i % 2 == 0, "R5 time lo");
    step(0, TMB + 4, 0, 1, "R5 time hi");
    // R2 R3: software bits
    step(1, SWB + 0, 32'h5, 1, "");
    step(1, SWB + 8, 32'h8000_0000, 0, "");
    step(1, SWB + 12, 0, 1, "");
    for (int h = 0; h < N; h++) step(0, SWB + 4 * h, 0, 0, "R3 swi read");
    step(1, SWB + 0, 0, 0, "");
    step(0, SWB + 0, 0, 0, "R3 swi cleared");
    // R4 R7: compare halves and deadline crossing
    step(1, CMB + 8, 32'd40, 0, "");
    step(1, CMB + 12, 32'd0, 0, "");
    step(0, CMB + 8, 0, 0, "R4 cmp lo");
    for (int i = 0; i < 40; i++) step(0, CMB + 12, 0, 1, "R4 cmp hi");
    step(1, CMB + 20, 32'd1, 0, "");
    step(1, CMB + 16, 32'd7, 1, "");
    step(0, CMB + 20, 0, 1, "R4 other half kept");
    step(0, CMB + 16, 0, 0, "R4 lo read");
    step(1, CMB + 24, mTime[31:0] + 32'd2, 1, "");
    for (int i = 0; i < 4; i++) step(0, CMB + 24, 0, 1, "R7 equal crossing");
    step(1, CMB + 24, mTime[31:0], 0, "");
    step(0, CMB + 24, 0, 0, "R7 equal now");
    // R6: time words not writable
    step(1, TMB, 32'hFFFF_0000, 0, "");
    step(1, TMB + 4, 32'h1234, 0, "R6 time hi");
    step(0, TMB, 0, 0, "R6 time lo");
    // R8: misaligned and unmapped
    step(1, SWB + 5, 32'h1, 0, "R8 misaligned");
    step(0, SWB + 4, 0, 0, "R8 misaligned write");
    step(1, CMB + 26, 32'hFFFF, 0, "R8 misaligned cmp");
    step(0, CMB + 24, 0, 0, "R8 cmp unchanged");
    step(1, 'h2000, 32'h1, 0, "R8 unmapped");
    step(0, 'h2000, 0, 0, "R8 unmapped read");
    // R9: hart index beyond count
    step(1, SWB + 4 * N, 32'h1, 0, "R9 swi beyond");
    step(0, SWB + 4 * N, 0, 0, "R9 swi beyond read");
    step(1, CMB + 8 * N, 32'h0, 0, "R9 cmp beyond");
    step(0, CMB + 8 * N + 4, 0, 1, "R9 cmp beyond hi");
    step(0, CMB, 0, 0, "R9 hart0 cmp intact");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule